// File: doc/BRIEF.md
# Fractional SPE Tributary Expander

This block sits on the egress side of a circuit-emulation path. It takes a compressed payload byte stream and rebuilds from it a complete 9-row by 87-column synchronous payload envelope. In the compressed stream, tributaries flagged as unequipped were dropped and the fixed-stuff columns were never sent. Each output byte carries its row and column, so downstream framing logic can place it without counting.

The block has one timing input, `adv`. Every cycle in which `adv` is high, the block emits the next envelope position. It takes the next byte from the compressed source only when that position holds a byte that was carried:
- path-overhead positions are carried;
- tributary positions whose mask bit is 0 are carried.

The other positions are filled locally with the value on `fill_byte`. Software normally ties `fill_byte` to 0x00. These filled positions are:
- tributary positions whose mask bit is 1;
- the two fixed-stuff columns.

The mask comes from the header's extension word. When the extension flag is clear, the mask is treated as all zero. The parity byte in row 2 of the overhead column is ORed with the bitwise parity of all dummy tributary bytes inserted in the previous envelope. This keeps the end-to-end parity consistent with the rule used by the compressor.

Top module: `frac_spe_expander`

## Requirements
- R1: While `adv` is high, output positions step row-major through rows 1..9 and columns 1..87, then wrap to row 1 column 1. `out_valid`, `out_byte`, `out_row`, `out_col` and `underflow` are registered and appear one cycle after the cycle that produced them.
- R2: Column 1 (path overhead) takes the next compressed input byte in stream order.
- R3: Columns 30 and 59 output `fill_byte` and consume no input.
- R4: Tributary columns are numbered by payload index k, which counts columns 2..87 from 0 and skips columns 30 and 59 (0..83 in each row). The slot is t = k mod N, where N = 28 when `vt2_mode` = 0 and N = 21 when `vt2_mode` = 1.
- R5: If mask bit t is 1, the slot outputs `fill_byte` and consumes nothing. If mask bit t is 0, the slot outputs the next compressed byte, so carried slots keep their stream order.
- R6: When `hdr_ext` = 0, every slot is treated as carried, whatever `hdr_mask` holds.
- R7: With `vt2_mode` = 1, mask bits 21..27 have no effect.
- R8: `hdr_ext`, `hdr_mask` and `vt2_mode` are sampled only at row 1 column 1 and held for the rest of that envelope. Changes later in the envelope have no effect until the next envelope.
- R9: The byte at row 2 column 1 is the input byte ORed with the XOR of all dummy tributary bytes inserted during the previous envelope. The first envelope after reset has a correction of 0.
- R10: If a carried position (column 1 or an unmasked slot) is reached while `in_valid` = 0, the block outputs `fill_byte`, raises `underflow` for that byte and consumes nothing.
- R11: During and right after reset, `out_valid`, `underflow` and `out_byte` are 0, and the position restarts at row 1 column 1.
- R12: While `adv` is low, the position holds, `out_valid` is 0 and `in_pop` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Emit one envelope position this cycle |
| vt2_mode | input | 1 | 0: 28 narrow tributaries, 1: 21 wide tributaries |
| hdr_ext | input | 1 | Extension word present; mask valid |
| hdr_mask | input | 28 | Unequipped mask, bit t = slot t removed |
| fill_byte | input | 8 | Value for dummy and stuff bytes |
| in_valid | input | 1 | Compressed byte available |
| in_data | input | 8 | Compressed byte |
| in_pop | output | 1 | Compressed byte consumed this cycle |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Rebuilt envelope byte |
| out_row | output | 4 | Row of output byte, 1..9 |
| out_col | output | 7 | Column of output byte, 1..87 |
| underflow | output | 1 | Carried position had no input byte |

## Verification
The assertions check properties that hold on every cycle:
- stuff columns always carry the fill value and never pop;
- an underflowed byte always equals the fill value;
- a pop never happens without `in_valid`;
- the row-2 overhead byte always contains every bit of the input byte;
- an idle `adv` holds the position and yields no output.

Other behaviour only the scenarios can show. This includes the exact slot-to-mask mapping in both tributary sizes and whether carried bytes keep their order. It also includes the sampling of the mask at the envelope boundary and the exact parity correction value carried into the next envelope.

// File: rtl/frac_spe_pkg.sv
package frac_spe_pkg;
    localparam int ROWS       = 9;
    localparam int COLS       = 87;
    localparam int STUFF_A    = 30;
    localparam int STUFF_B    = 59;
    localparam int SLOTS_NARROW = 28;
    localparam int SLOTS_WIDE   = 21;
    localparam int MASK_W     = SLOTS_NARROW;
    localparam int ROW_W      = $clog2(ROWS + 1);
    localparam int COL_W      = $clog2(COLS + 1);
    localparam int SLOT_W     = $clog2(MASK_W);

    typedef enum logic [1:0] {
        KIND_OVH   = 2'd0,
        KIND_STUFF = 2'd1,
        KIND_TRIB  = 2'd2
    } col_kind_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } spe_pos_t;

    function automatic col_kind_e kind_of(input logic [COL_W-1:0] col);
        if (col == COL_W'(1))
            return KIND_OVH;
        else if (col == COL_W'(STUFF_A) || col == COL_W'(STUFF_B))
            return KIND_STUFF;
        else
            return KIND_TRIB;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [COL_W-1:0] col,
                                                 input logic wide);
        logic [COL_W-1:0] k;
        k = col - COL_W'(2)
              - ((col > COL_W'(STUFF_A)) ? COL_W'(1) : COL_W'(0))
              - ((col > COL_W'(STUFF_B)) ? COL_W'(1) : COL_W'(0));
        if (wide)
            return SLOT_W'(k % COL_W'(SLOTS_WIDE));
        else
            return SLOT_W'(k % COL_W'(SLOTS_NARROW));
    endfunction
endpackage

// File: rtl/spe_pos_counter.sv
module spe_pos_counter
    import frac_spe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    output spe_pos_t pos,
    output logic     frame_first,
    output logic     frame_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pos.row <= ROW_W'(1);
            pos.col <= COL_W'(1);
        end else if (adv) begin
            if (pos.col == COL_W'(COLS)) begin
                pos.col <= COL_W'(1);
                pos.row <= (pos.row == ROW_W'(ROWS)) ? ROW_W'(1) : pos.row + ROW_W'(1);
            end else begin
                pos.col <= pos.col + COL_W'(1);
            end
        end
    end

    assign frame_first = (pos.row == ROW_W'(1))    && (pos.col == COL_W'(1));
    assign frame_last  = (pos.row == ROW_W'(ROWS)) && (pos.col == COL_W'(COLS));

    // R12
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos));

    // R1
    pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && frame_last) |=> frame_first);
endmodule

// File: rtl/spe_slot_select.sv
module spe_slot_select
    import frac_spe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              adv,
    input  spe_pos_t          pos,
    input  logic [MASK_W-1:0] mask,
    input  logic              wide,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] fill,
    input  logic [DATA_W-1:0] b3_fix,
    output logic              pop,
    output logic [DATA_W-1:0] byte_out,
    output logic              starve,
    output logic              dummy
);
    localparam logic [ROW_W-1:0] B3_ROW = ROW_W'(2);

    col_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic              carried;

    always_comb begin
        kind     = kind_of(pos.col);
        slot     = slot_of(pos.col, wide);
        carried  = 1'b0;
        dummy    = 1'b0;
        byte_out = fill;
        unique case (kind)
            KIND_OVH:   carried = 1'b1;
            KIND_STUFF: carried = 1'b0;
            default: begin
                carried = !mask[slot];
                dummy   = mask[slot];
            end
        endcase
        starve = carried && !in_valid;
        pop    = adv && carried && in_valid;
        if (carried && in_valid) begin
            byte_out = in_data;
            if (kind == KIND_OVH && pos.row == B3_ROW)
                byte_out = in_data | b3_fix;
        end
    end
endmodule

// File: rtl/spe_b3_fold.sv
module spe_b3_fold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              dummy,
    input  logic [DATA_W-1:0] fill,
    input  logic              frame_last,
    output logic [DATA_W-1:0] b3_fix
);
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] acc_n;

    assign acc_n = acc ^ (dummy ? fill : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            b3_fix <= '0;
        end else if (adv) begin
            if (frame_last) begin
                b3_fix <= acc_n;
                acc    <= '0;
            end else begin
                acc <= acc_n;
            end
        end
    end

    // R9
    b3_fix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(adv && frame_last) |=> $stable(b3_fix));
endmodule

// File: rtl/frac_spe_expander.sv
module frac_spe_expander
    import frac_spe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              vt2_mode,
    input  logic              hdr_ext,
    input  logic [27:0]       hdr_mask,
    input  logic [DATA_W-1:0] fill_byte,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_pop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_byte,
    output logic [3:0]        out_row,
    output logic [6:0]        out_col,
    output logic              underflow
);
    spe_pos_t          pos;
    logic              frame_first;
    logic              frame_last;
    logic [MASK_W-1:0] mask_q;
    logic              wide_q;
    logic [DATA_W-1:0] sel_byte;
    logic              sel_starve;
    logic              sel_dummy;
    logic [DATA_W-1:0] b3_fix;

    spe_pos_counter u_pos (
        .clk(clk), .rst(rst), .adv(adv),
        .pos(pos), .frame_first(frame_first), .frame_last(frame_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            wide_q <= 1'b0;
        end else if (adv && frame_first) begin
            mask_q <= hdr_ext ? hdr_mask : '0;
            wide_q <= vt2_mode;
        end
    end

    spe_slot_select #(.DATA_W(DATA_W)) u_sel (
        .adv(adv), .pos(pos), .mask(mask_q), .wide(wide_q),
        .in_valid(in_valid), .in_data(in_data), .fill(fill_byte),
        .b3_fix(b3_fix), .pop(in_pop), .byte_out(sel_byte),
        .starve(sel_starve), .dummy(sel_dummy)
    );

    spe_b3_fold #(.DATA_W(DATA_W)) u_b3 (
        .clk(clk), .rst(rst), .adv(adv), .dummy(sel_dummy),
        .fill(fill_byte), .frame_last(frame_last), .b3_fix(b3_fix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_row   <= 4'd1;
            out_col   <= 7'd1;
            underflow <= 1'b0;
        end else begin
            out_valid <= adv;
            underflow <= adv && sel_starve;
            if (adv) begin
                out_byte <= sel_byte;
                out_row  <= 4'(pos.row);
                out_col  <= 7'(pos.col);
            end
        end
    end

    // R3
    stuff_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_col == 7'd30 || out_col == 7'd59))
            |-> out_byte == $past(fill_byte));

    // R3
    stuff_nopop_chk: assert property (@(posedge clk) disable iff (rst)
        in_pop |-> (kind_of(pos.col) != KIND_STUFF));

    // R10
    underflow_fill_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (out_valid && out_byte == $past(fill_byte)));

    // R10
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        in_pop |-> in_valid);

    // R9
    b3_or_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !underflow && out_row == 4'd2 && out_col == 7'd1)
            |-> ((out_byte & $past(in_data)) == $past(in_data)));

    // R12
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> !out_valid);
endmodule

// File: tb/test_frac_spe_expander.sv
module test_frac_spe_expander;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        adv;
    logic        vt2_mode;
    logic        hdr_ext;
    logic [27:0] hdr_mask;
    logic [7:0]  fill_byte;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_pop;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic [3:0]  out_row;
    logic [6:0]  out_col;
    logic        underflow;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    int         src_idx = 0;
    logic [7:0] m_acc   = 8'h00;
    logic [7:0] m_fix   = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_spe_expander i_frac_spe_expander (
        .clk(clk), .rst(rst), .adv(adv), .vt2_mode(vt2_mode),
        .hdr_ext(hdr_ext), .hdr_mask(hdr_mask), .fill_byte(fill_byte),
        .in_valid(in_valid), .in_data(in_data), .in_pop(in_pop),
        .out_valid(out_valid), .out_byte(out_byte), .out_row(out_row),
        .out_col(out_col), .underflow(underflow)
    );

    function automatic logic [7:0] src(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; adv = 1'b0; vt2_mode = 1'b0; hdr_ext = 1'b0;
        hdr_mask = '0; fill_byte = 8'h00; in_valid = 1'b0; in_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check(out_valid == 1'b0, "R11", "out_valid", 32'(out_valid), 32'd0);
        check(underflow == 1'b0, "R11", "underflow", 32'(underflow), 32'd0);
        check(out_byte == 8'h00, "R11", "out_byte", 32'(out_byte), 32'd0);
        check(in_pop == 1'b0, "R11", "in_pop", 32'(in_pop), 32'd0);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    // One full envelope; every position checked against the model.
    task automatic run_frame(input logic [27:0] m, input logic ext, input logic wide,
                             input logic [7:0] fill, input int starve_lo,
                             input int starve_hi, input int gap_at,
                             input logic [27:0] m_mid, input string tag);
        logic [27:0] lm;
        logic        lwide;
        int          n;
        lm    = ext ? m : 28'h0;
        lwide = wide;
        n     = wide ? 21 : 28;
        hdr_mask = m; hdr_ext = ext; vt2_mode = wide; fill_byte = fill;
        for (int p = 0; p < 783; p++) begin
            int         r, c, k, t;
            bit         carried, dum, starving, exp_pop;
            logic [7:0] exp_b;
            string      req;
            if (p == gap_at) begin
                for (int g = 0; g < 3; g++) begin
                    adv = 1'b0; in_valid = 1'b1; in_data = src(src_idx);
                    @(negedge clk);
                    // R12 idle: no pop
                    check(in_pop == 1'b0, "R12", "in_pop idle", 32'(in_pop), 32'd0);
                    @(posedge clk); #1;
                    // R12 idle: no output
                    check(out_valid == 1'b0, "R12", "out_valid idle", 32'(out_valid), 32'd0);
                end
            end
            if (p == 400) hdr_mask = m_mid;
            r = p / 87 + 1;
            c = p % 87 + 1;
            starving = (p >= starve_lo) && (p < starve_hi);
            adv = 1'b1; in_valid = !starving; in_data = src(src_idx);
            carried = 1'b0; dum = 1'b0; req = tag;
            if (c == 1) begin
                carried = 1'b1; req = (r == 2) ? "R9" : "R2";
            end else if (c == 30 || c == 59) begin
                req = "R3";
            end else begin
                k = c - 2 - ((c > 30) ? 1 : 0) - ((c > 59) ? 1 : 0);
                t = k % n;
                dum = lm[t];
                carried = !dum;
            end
            exp_pop = carried && !starving;
            if (carried && starving) req = "R10";
            exp_b = fill;
            if (exp_pop) begin
                exp_b = src(src_idx);
                if (c == 1 && r == 2) exp_b = exp_b | m_fix;
            end
            if (dum) m_acc = m_acc ^ fill;
            @(negedge clk);
            check(in_pop == exp_pop, req, $sformatf("in_pop r%0d c%0d", r, c),
                  32'(in_pop), 32'(exp_pop));
            @(posedge clk); #1;
            if (exp_pop) src_idx++;
            // R1 position markers plus byte and underflow
            check({out_valid, underflow, out_row, out_col, out_byte} ==
                  {1'b1, (carried && starving), 4'(r), 7'(c), exp_b}, req,
                  $sformatf("out r%0d c%0d {v,uf,row,col,byte}", r, c),
                  32'({out_valid, underflow, out_row, out_col, out_byte}),
                  32'({1'b1, (carried && starving), 4'(r), 7'(c), exp_b}));
        end
        m_fix = m_acc;
        m_acc = 8'h00;
        adv = 1'b0;
        if (lwide) begin end
    endtask

    task automatic t_no_ext();
        // R6: extension absent, mask of all ones must be ignored
        run_frame(28'hFFF_FFFF, 1'b0, 1'b0, 8'h00, -1, -1, -1, 28'hFFF_FFFF, "R6");
    endtask

    task automatic t_narrow_mask();
        // R4 R5: narrow slots, odd mask popcount gives nonzero parity fold
        run_frame(28'h5A5_A5A7, 1'b1, 1'b0, 8'hA5, -1, -1, -1, 28'h5A5_A5A7, "R5");
    endtask

    task automatic t_mid_change();
        // R8: mask changed mid-envelope must not apply; R9 fold from previous
        run_frame(28'h000_0003, 1'b1, 1'b0, 8'h3C, -1, -1, -1, 28'hFFF_FFFF, "R8");
    endtask

    task automatic t_wide_mask();
        // R7: wide slots, bits 21..27 set but ignored; R12 gap inside
        run_frame(28'hFE0_0015, 1'b1, 1'b1, 8'h81, -1, -1, 200, 28'hFE0_0015, "R7");
    endtask

    task automatic t_starve();
        // R10: input runs dry over a window of positions
        run_frame(28'h000_0000, 1'b1, 1'b0, 8'h11, 80, 130, -1, 28'h000_0000, "R10");
    endtask

    task automatic t_resume_b3();
        // R9: envelope following the wide frame uses its fold value
        run_frame(28'h000_0000, 1'b1, 1'b0, 8'h00, -1, -1, -1, 28'h000_0000, "R4");
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_no_ext();
        t_narrow_mask();
        t_mid_change();
        t_wide_mask();
        t_resume_b3();
        t_starve();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule